// File: doc/BRIEF.md
# Console Line Marker Detector

This block sits on the transmit byte stream of a console and forwards every byte unchanged. As it forwards the stream, it cuts the stream into lines at newline bytes. At the end of each line it reports which fixed marker strings occurred anywhere in that line. A counting marker advances a line counter. Event markers set sticky flags, which software or control logic polls later. A prefix marker introduces a hexadecimal field, and the block decodes that field into a latched value. When the line carrying the "ready" event marker ends and auto-reply is enabled, the block pushes a two-byte acknowledgement into a receive-side push port.

Matching runs on the fly. A sliding history of the most recent line bytes is compared against every marker, and hit bits accumulate per line. At the newline, the accumulated hits are committed and then cleared. All marker strings, lengths and widths are elaboration parameters.

Top module: `console_marker_watch`

## Requirements
- R1: `tx_out_valid`/`tx_out_data` equal `tx_valid`/`tx_data` in the same cycle, whether or not the detector is enabled.
- R2: Byte 0x0A ends a line and is not part of it. The next line starts empty, so a marker split across a newline never matches.
- R3: A marker matches at any position in a line. Only the first MAX_LINE (default 4096) bytes of a line are retained. Later bytes up to the newline are dropped and cannot contribute to a match.
- R4: `line_count` (64 bits) rises by exactly one at the end of each line containing the counting marker (default `tick n=`), however many times the marker occurs in that line. The new value is visible the cycle after the newline.
- R5: `evt_flags` bit i is set at the end of a line containing event marker i and stays set. The defaults are bit 0 `sys ready`, bit 1 `sys resumed` and bit 2 `job parked`.
- R6: After the first occurrence of the prefix marker (default `addr=0x`) in a line, up to 16 following bytes are read as hex digits, case-insensitive. Reading stops at the first non-hex byte. At the newline, `hex_value` loads the result only if at least one digit was read; otherwise it keeps its value.
- R7: If a line containing the ready marker ends while `auto_reply_en` is 1, `rx_push_valid` goes high the next cycle with data 0x52. After that byte is accepted (`rx_push_valid` and `rx_push_ready` both high), the data becomes 0x0A, and after that byte is accepted the port goes idle. With `auto_reply_en` at 0, nothing is pushed.
- R8: While `rx_push_valid` is high and `rx_push_ready` is low, `rx_push_valid` and `rx_push_data` hold.
- R9: While `det_en` is 0, input bytes (newlines included) leave the counter, the flags, the hex value and the current line unchanged.
- R10: `clr` zeroes `line_count`, `evt_flags` and `hex_value` on the next cycle, and it takes precedence over a newline in the same cycle.
- R11: After reset, the counter, the flags and the hex value are zero and `rx_push_valid` is 0.
- R12: A ready line that ends while a reply is still in progress causes no further reply bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detector enable |
| auto_reply_en | input | 1 | Enables the two-byte reply on ready lines |
| clr | input | 1 | Clears counter, flags and hex value |
| tx_valid | input | 1 | Transmit byte strobe |
| tx_data | input | 8 | Transmit byte |
| tx_out_valid | output | 1 | Forwarded byte strobe |
| tx_out_data | output | 8 | Forwarded byte |
| line_count | output | CNT_W | Count of lines holding the counting marker |
| evt_flags | output | N_EVT | Sticky event flags |
| hex_value | output | HEX_W | Last latched hex field |
| rx_push_valid | output | 1 | Reply byte available |
| rx_push_data | output | 8 | Reply byte |
| rx_push_ready | input | 1 | Receiver accepts the reply byte |

## Verification
The byte forwarding is combinational, so the bench compares it in the cycle the byte is driven. The counter, the flags and the hex value all commit on the clock edge that takes the newline. A reply byte first appears on that same edge, and each accepted reply byte advances the port on the edge of acceptance. The bench drives inputs just after a rising edge and compares every output against its behavioural line model at the falling edge. Directed spot checks are sampled one step after the edge that carries the event.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
  localparam int MARK_BYTES = 32;
  localparam int FILL_W = $clog2(MARK_BYTES + 1);

  typedef logic [MARK_BYTES*8-1:0] mark_t;

  typedef enum logic [1:0] {P_IDLE, P_DIGITS, P_DONE} pstate_e;
  typedef enum logic [1:0] {R_IDLE, R_FIRST, R_SECOND} rstate_e;

  // bit 4 flags a valid hex digit, bits 3:0 hold its value
  function automatic logic [4:0] hex_nib(input logic [7:0] c);
    logic [7:0] t;
    if (c >= 8'h30 && c <= 8'h39) begin
      t = c - 8'h30;
      return {1'b1, t[3:0]};
    end else if (c >= 8'h61 && c <= 8'h66) begin
      t = c - 8'h57;
      return {1'b1, t[3:0]};
    end else if (c >= 8'h41 && c <= 8'h46) begin
      t = c - 8'h37;
      return {1'b1, t[3:0]};
    end
    return 5'd0;
  endfunction
endpackage

// File: rtl/cmw_marker_match.sv
module cmw_marker_match
  import cmw_pkg::*;
#(
  parameter mark_t MARK = '0,
  parameter int    LEN  = 1
) (
  input  mark_t             hist,
  input  logic [FILL_W-1:0] fill,
  output logic              hit
);
  logic [MARK_BYTES-1:0] byte_ok;

  // newest byte sits in the low byte of both the history and the marker
  always_comb begin
    for (int i = 0; i < MARK_BYTES; i++) begin
      byte_ok[i] = (i >= LEN) || (hist[8*i +: 8] == MARK[8*i +: 8]);
    end
  end

  assign hit = (&byte_ok) && (fill >= FILL_W'(LEN));
endmodule

// File: rtl/cmw_hex_field.sv
module cmw_hex_field
  import cmw_pkg::*;
#(
  parameter int VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_kept,
  input  logic             line_end,
  input  logic             prefix_hit,
  input  logic [7:0]       byte_in,
  output logic             latch_en,
  output logic [VAL_W-1:0] latch_val
);
  localparam int MAX_DIG = VAL_W / 4;
  localparam int DIG_W   = $clog2(MAX_DIG + 1);

  pstate_e          st_q, st_d;
  logic [VAL_W-1:0] acc_q, acc_d;
  logic [DIG_W-1:0] dig_q, dig_d;
  logic [4:0]       nib;
  logic             step_en;

  assign nib     = hex_nib(byte_in);
  assign step_en = line_end | byte_kept;

  always_comb begin
    st_d  = st_q;
    acc_d = acc_q;
    dig_d = dig_q;
    if (line_end) begin
      st_d  = P_IDLE;
      acc_d = '0;
      dig_d = '0;
    end else begin
      case (st_q)
        P_IDLE: if (prefix_hit) st_d = P_DIGITS;
        P_DIGITS: begin
          if (nib[4]) begin
            acc_d = {acc_q[VAL_W-5:0], nib[3:0]};
            dig_d = dig_q + DIG_W'(1);
            if (dig_q == DIG_W'(MAX_DIG - 1)) st_d = P_DONE;
          end else begin
            st_d = P_DONE;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= P_IDLE;
      acc_q <= '0;
      dig_q <= '0;
    end else if (step_en) begin
      st_q  <= st_d;
      acc_q <= acc_d;
      dig_q <= dig_d;
    end
  end

  assign latch_en  = line_end && (dig_q != '0);
  assign latch_val = acc_q;
endmodule

// File: rtl/cmw_reply_inject.sv
module cmw_reply_inject
  import cmw_pkg::*;
#(
  parameter logic [7:0] FIRST  = 8'h52,
  parameter logic [7:0] SECOND = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       push_ready,
  output logic       push_valid,
  output logic [7:0] push_data
);
  rstate_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      R_IDLE:   if (req) st_d = R_FIRST;
      R_FIRST:  if (push_ready) st_d = R_SECOND;
      R_SECOND: if (push_ready) st_d = R_IDLE;
      default:  st_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= R_IDLE;
    else        st_q <= st_d;
  end

  assign push_valid = (st_q != R_IDLE);
  assign push_data  = (st_q == R_SECOND) ? SECOND : FIRST;
endmodule

// File: rtl/console_marker_watch.sv
module console_marker_watch
  import cmw_pkg::*;
#(
  parameter int                      MAX_LINE  = 4096,
  parameter int                      CNT_W     = 64,
  parameter int                      HEX_W     = 64,
  parameter int                      N_EVT     = 3,
  parameter int                      READY_IDX = 0,
  parameter mark_t                   CNT_MARK  = "tick n=",
  parameter int                      CNT_LEN   = 7,
  parameter mark_t                   PFX_MARK  = "addr=0x",
  parameter int                      PFX_LEN   = 7,
  parameter mark_t [N_EVT-1:0]       EVT_MARK  = '{"job parked", "sys resumed", "sys ready"},
  parameter logic [N_EVT-1:0][5:0]   EVT_LEN   = '{6'd10, 6'd11, 6'd9}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic             auto_reply_en,
  input  logic             clr,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_out_valid,
  output logic [7:0]       tx_out_data,
  output logic [CNT_W-1:0] line_count,
  output logic [N_EVT-1:0] evt_flags,
  output logic [HEX_W-1:0] hex_value,
  output logic             rx_push_valid,
  output logic [7:0]       rx_push_data,
  input  logic             rx_push_ready
);
  localparam int LEN_W = $clog2(MAX_LINE + 1);
  localparam logic [7:0] NEWLINE = 8'h0A;

  // forwarding path
  assign tx_out_valid = tx_valid;
  assign tx_out_data  = tx_data;

  // byte classification
  logic fire, is_nl, keep, line_en, stat_en;
  logic [LEN_W-1:0] len_q, len_d;

  assign fire    = det_en && tx_valid;
  assign is_nl   = fire && (tx_data == NEWLINE);
  assign keep    = fire && !is_nl && (len_q < LEN_W'(MAX_LINE));
  assign line_en = is_nl | keep;
  assign stat_en = is_nl | clr;

  // sliding history of the current line
  mark_t             hist_q, hist_d, hist_nx;
  logic [FILL_W-1:0] fill_q, fill_d, fill_nx;

  assign hist_nx = {hist_q[MARK_BYTES*8-9:0], tx_data};
  assign fill_nx = (fill_q == FILL_W'(MARK_BYTES)) ? fill_q : fill_q + FILL_W'(1);

  // matchers
  logic             cnt_now, pfx_now;
  logic [N_EVT-1:0] evt_now;

  cmw_marker_match #(.MARK(CNT_MARK), .LEN(CNT_LEN)) u_cnt_match (
    .hist(hist_nx), .fill(fill_nx), .hit(cnt_now));

  cmw_marker_match #(.MARK(PFX_MARK), .LEN(PFX_LEN)) u_pfx_match (
    .hist(hist_nx), .fill(fill_nx), .hit(pfx_now));

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    cmw_marker_match #(.MARK(EVT_MARK[e]), .LEN(int'(EVT_LEN[e]))) u_evt_match (
      .hist(hist_nx), .fill(fill_nx), .hit(evt_now[e]));
  end

  // per-line hit bits
  logic             cnt_hit_q, cnt_hit_d;
  logic [N_EVT-1:0] evt_hit_q, evt_hit_d;

  always_comb begin
    if (is_nl) begin
      hist_d    = '0;
      fill_d    = '0;
      len_d     = '0;
      cnt_hit_d = 1'b0;
      evt_hit_d = '0;
    end else begin
      hist_d    = hist_nx;
      fill_d    = fill_nx;
      len_d     = len_q + LEN_W'(1);
      cnt_hit_d = cnt_hit_q | cnt_now;
      evt_hit_d = evt_hit_q | evt_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      fill_q    <= '0;
      len_q     <= '0;
      cnt_hit_q <= 1'b0;
      evt_hit_q <= '0;
    end else if (line_en) begin
      hist_q    <= hist_d;
      fill_q    <= fill_d;
      len_q     <= len_d;
      cnt_hit_q <= cnt_hit_d;
      evt_hit_q <= evt_hit_d;
    end
  end

  // hex field extraction
  logic             hex_latch;
  logic [HEX_W-1:0] hex_val;

  cmw_hex_field #(.VAL_W(HEX_W)) u_hex (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_kept (keep),
    .line_end  (is_nl),
    .prefix_hit(pfx_now),
    .byte_in   (tx_data),
    .latch_en  (hex_latch),
    .latch_val (hex_val)
  );

  // committed results
  logic [CNT_W-1:0] count_q, count_d;
  logic [N_EVT-1:0] flags_q, flags_d;
  logic [HEX_W-1:0] hexv_q, hexv_d;

  always_comb begin
    count_d = count_q;
    flags_d = flags_q;
    hexv_d  = hexv_q;
    if (is_nl) begin
      if (cnt_hit_q) count_d = count_q + CNT_W'(1);
      flags_d = flags_q | evt_hit_q;
    end
    if (hex_latch) hexv_d = hex_val;
    if (clr) begin
      count_d = '0;
      flags_d = '0;
      hexv_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      flags_q <= '0;
      hexv_q  <= '0;
    end else if (stat_en) begin
      count_q <= count_d;
      flags_q <= flags_d;
      hexv_q  <= hexv_d;
    end
  end

  assign line_count = count_q;
  assign evt_flags  = flags_q;
  assign hex_value  = hexv_q;

  // auto reply
  logic reply_req;
  assign reply_req = is_nl && evt_hit_q[READY_IDX] && auto_reply_en;

  cmw_reply_inject #(.FIRST(8'h52), .SECOND(NEWLINE)) u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (reply_req),
    .push_ready(rx_push_ready),
    .push_valid(rx_push_valid),
    .push_data (rx_push_data)
  );
endmodule

// File: rtl/cmw_checker.sv
module cmw_checker #(
  parameter int CNT_W = 64,
  parameter int HEX_W = 64,
  parameter int N_EVT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_en,
  input logic             clr,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             rx_push_valid,
  input logic             rx_push_ready,
  input logic [7:0]       rx_push_data,
  input logic [CNT_W-1:0] line_count,
  input logic [N_EVT-1:0] evt_flags,
  input logic [HEX_W-1:0] hex_value
);
  logic nl_in;
  assign nl_in = det_en && tx_valid && (tx_data == 8'h0A);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (line_count == $past(line_count)) || (line_count == $past(line_count) + CNT_W'(1)));

  assert_count_at_eol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nl_in && !clr |=> $stable(line_count));

  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((evt_flags & $past(evt_flags)) == $past(evt_flags)));

  assert_hex_at_eol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nl_in && !clr |=> $stable(hex_value));

  assert_reply_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_valid && rx_push_ready && (rx_push_data == 8'h52) |=> rx_push_valid && (rx_push_data == 8'h0A));

  assert_reply_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_valid && !rx_push_ready |=> rx_push_valid && $stable(rx_push_data));

  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en && !clr |=> $stable(line_count) && $stable(evt_flags) && $stable(hex_value));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (line_count == '0) && (evt_flags == '0) && (hex_value == '0));
endmodule

bind console_marker_watch cmw_checker #(
  .CNT_W(CNT_W), .HEX_W(HEX_W), .N_EVT(N_EVT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .det_en       (det_en),
  .clr          (clr),
  .tx_valid     (tx_valid),
  .tx_data      (tx_data),
  .rx_push_valid(rx_push_valid),
  .rx_push_ready(rx_push_ready),
  .rx_push_data (rx_push_data),
  .line_count   (line_count),
  .evt_flags    (evt_flags),
  .hex_value    (hex_value)
);

// File: tb/console_marker_watch_tb_top.sv
module console_marker_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        det_en = 1'b0;
  logic        auto_reply_en = 1'b0;
  logic        clr = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        rx_push_ready = 1'b1;
  logic        tx_out_valid;
  logic [7:0]  tx_out_data;
  logic [63:0] line_count;
  logic [2:0]  evt_flags;
  logic [63:0] hex_value;
  logic        rx_push_valid;
  logic [7:0]  rx_push_data;

  always #4 clk = ~clk;

  console_marker_watch dut_i (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .auto_reply_en(auto_reply_en),
    .clr(clr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .line_count(line_count), .evt_flags(evt_flags), .hex_value(hex_value),
    .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data),
    .rx_push_ready(rx_push_ready)
  );

  int checks = 0;
  int fails = 0;
  int pushes = 0;
  bit started = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  byte unsigned lq[$];
  logic [63:0] m_cnt;
  logic [2:0]  m_flags;
  logic [63:0] m_hex;
  int          m_rep;

  function automatic int find_str(input string s);
    for (int p = 0; p + s.len() <= lq.size(); p++) begin
      bit ok;
      ok = 1;
      for (int k = 0; k < s.len(); k++) if (lq[p+k] != s[k]) ok = 0;
      if (ok) return p;
    end
    return -1;
  endfunction

  function automatic int hexval(input byte unsigned c);
    if (c >= "0" && c <= "9") return c - "0";
    if (c >= "a" && c <= "f") return c - "a" + 10;
    if (c >= "A" && c <= "F") return c - "A" + 10;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    int old_rep, p, n, nib;
    bit req;
    logic [63:0] v;
    if (!rst_n) begin
      lq.delete();
      m_cnt = 0; m_flags = 0; m_hex = 0; m_rep = 0;
      if (clk) started = 1;
    end else begin
      started = 1;
      req = 0;
      old_rep = m_rep;
      if (det_en && tx_valid) begin
        if (tx_data == 8'h0A) begin
          if (find_str("tick n=") >= 0) m_cnt = m_cnt + 1;
          if (find_str("sys ready") >= 0) begin m_flags[0] = 1; req = auto_reply_en; end
          if (find_str("sys resumed") >= 0) m_flags[1] = 1;
          if (find_str("job parked") >= 0) m_flags[2] = 1;
          p = find_str("addr=0x");
          if (p >= 0) begin
            n = 0; v = 0;
            for (int k = p + 7; k < lq.size() && n < 16; k++) begin
              nib = hexval(lq[k]);
              if (nib < 0) break;
              v = {v[59:0], 4'(nib)};
              n++;
            end
            if (n > 0) m_hex = v;
          end
          lq.delete();
        end else if (lq.size() < 4096) begin
          lq.push_back(tx_data);
        end
      end
      if (clr) begin m_cnt = 0; m_flags = 0; m_hex = 0; end
      if (old_rep == 1 && rx_push_ready) m_rep = 2;
      else if (old_rep == 2 && rx_push_ready) m_rep = 0;
      if (req && old_rep == 0) m_rep = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done_run) begin
      chk(tx_out_valid == tx_valid && tx_out_data == tx_data, "R1 passthrough",
          {55'd0, tx_out_valid, tx_out_data}, {55'd0, tx_valid, tx_data});
      chk(line_count == m_cnt, "R4 line_count", line_count, m_cnt);
      chk(evt_flags == m_flags, "R5 evt_flags", 64'(evt_flags), 64'(m_flags));
      chk(hex_value == m_hex, "R6 hex_value", hex_value, m_hex);
      chk(rx_push_valid == (m_rep != 0), "R7 rx_push_valid", 64'(rx_push_valid), 64'(m_rep != 0));
      if (m_rep != 0)
        chk(rx_push_data == ((m_rep == 1) ? 8'h52 : 8'h0A), "R8 rx_push_data",
            64'(rx_push_data), (m_rep == 1) ? 64'h52 : 64'h0A);
      if (rx_push_valid && rx_push_ready) pushes++;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    tx_valid = 1'b1;
    tx_data  = b;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic send_rep(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) send_byte(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin : stim
    idle(3);
    // R11 reset state
    chk(line_count == 0 && evt_flags == 0 && hex_value == 0 && !rx_push_valid, "R11 reset",
        line_count | 64'(evt_flags) | hex_value, 64'd0);
    rst_n = 1'b1;
    det_en = 1'b1;
    idle(2);

    // R4: one per line, even with repeats
    send_str("tick n=1\n");
    chk(line_count == 1, "R4 single", line_count, 1);
    send_str("a tick n= tick n=\n");
    chk(line_count == 2, "R4 once per line", line_count, 2);
    // R2: marker split by a newline does not match
    send_str("tick \n n=\n");
    idle(2);
    chk(line_count == 2, "R2 split", line_count, 2);

    // R7: auto reply with receiver ready
    auto_reply_en = 1'b1;
    send_str("boot sys ready\n");
    chk(rx_push_valid && rx_push_data == 8'h52, "R7 first byte", {56'd0, rx_push_data}, 64'h52);
    pushes = 0;
    idle(5);
    chk(pushes == 2 && !rx_push_valid, "R7 two bytes", 64'(pushes), 2);

    // R8 hold under back-pressure, R12 drop while busy
    rx_push_ready = 1'b0;
    send_str("sys ready\n");
    idle(3);
    chk(rx_push_valid && rx_push_data == 8'h52, "R8 hold", {56'd0, rx_push_data}, 64'h52);
    pushes = 0;
    send_str("sys ready again\n");
    rx_push_ready = 1'b1;
    idle(6);
    chk(pushes == 2 && !rx_push_valid, "R12 dropped request", 64'(pushes), 2);

    // R5 sticky flags
    send_str("job parked\n");
    idle(1);
    send_str("xx sys resumed yy\n");
    chk(evt_flags == 3'b111, "R5 flags", 64'(evt_flags), 7);
    send_str("nothing here\n");
    chk(evt_flags == 3'b111, "R5 sticky", 64'(evt_flags), 7);

    // R6 hex field
    send_str("addr=0xDeadBEef12\n");
    chk(hex_value == 64'hdeadbeef12, "R6 mixed case", hex_value, 64'hdeadbeef12);
    send_str("addr=0x\n");
    chk(hex_value == 64'hdeadbeef12, "R6 no digits", hex_value, 64'hdeadbeef12);
    send_str("addr=0x0123456789abcdef99\n");
    chk(hex_value == 64'h0123456789abcdef, "R6 sixteen digits", hex_value, 64'h0123456789abcdef);
    send_str("q addr=0x5g addr=0x7\n");
    chk(hex_value == 64'h5, "R6 first prefix", hex_value, 64'h5);

    // R3 line limit
    send_rep("a", 4096);
    send_str("tick n=\n");
    chk(line_count == 2, "R3 dropped tail", line_count, 2);
    send_rep("a", 4089);
    send_str("tick n=\n");
    chk(line_count == 3, "R3 at limit", line_count, 3);

    // R9 disabled detector
    det_en = 1'b0;
    send_str("tick n=\n");
    send_str("tick n=");
    chk(tx_out_valid == 1'b0 && line_count == 3, "R9 ignored", line_count, 3);
    det_en = 1'b1;
    send_str("\n");
    chk(line_count == 3, "R9 no line state", line_count, 3);

    // R7 with auto reply off
    auto_reply_en = 1'b0;
    pushes = 0;
    send_str("sys ready\n");
    idle(4);
    chk(pushes == 0 && !rx_push_valid, "R7 disabled", 64'(pushes), 0);

    // R10 clear beats newline
    send_str("tick n=");
    tx_valid = 1'b1; tx_data = 8'h0A; clr = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0; clr = 1'b0;
    chk(line_count == 0 && evt_flags == 0 && hex_value == 0, "R10 clear",
        line_count | 64'(evt_flags) | hex_value, 0);
    send_str("tick n=\n");
    chk(line_count == 1, "R10 after clear", line_count, 1);

    idle(3);
    finish_run();
  end
endmodule